// File: doc/BRIEF.md
# Hex Record Stream Decoder

This block takes ASCII text one character at a time over a valid/ready handshake and decodes hexadecimal load records of the Motorola S-record kind. Each record starts with the letter S. A type digit follows, then a two-character byte count, then an address field whose width depends on the type. After that come the data bytes and a one-byte checksum. For every data byte that the record type stores, the block issues a one-cycle write strobe. The strobe carries the byte and its offset from the load base, so a memory placed next to the block can rebuild the image.

The address of the first record whose type is not 0 becomes the load base. The block keeps a running image size, verifies each record's checksum, and stops on a termination record, where it reports that record's address as the start address. A character between records that is neither blank nor S, or a checksum that does not match, stops decoding with an error flag. After an error or after completion, the block accepts no further input until a synchronous restart pulse returns it to its reset state.

Top module: `srec_stream_decoder`

## Requirements
- R1: Carriage return (0x0D), line feed (0x0A) and space (0x20) that arrive while the decoder waits for a record are consumed with no effect. Any other character there except 'S' (0x53) sets `err_nos` and halts the decoder.
- R2: Each hex character becomes a nibble by adding 9 when bit 6 of the character is set and then keeping the low four bits, so '0'-'9', 'A'-'F' and 'a'-'f' are all accepted.
- R3: The character after 'S' is the type. The address field has 4 hex characters for types 1 and 9, 6 for types 2 and 8, 8 for types 3 and 7, and none for type 0, for types 4, 5 and 6, or for type digits A-F. The address is read most significant nibble first.
- R4: The two characters after the type give the byte count L, high nibble first. The record then holds max(0, L − 1 − address bytes) data bytes, each formed from two characters with the high nibble first, followed by one checksum byte.
- R5: A record is accepted when its final byte equals the bitwise inverse of the 8-bit sum of L, every address byte and every data byte. On a mismatch the decoder sets `err_sum`, puts the record address on `err_addr`, and halts.
- R6: The address of the first record whose type is not 0 is latched on `load_base`, and `base_valid` rises at that point. Neither changes again until restart.
- R7: For types 1, 2, 3, 7, 8 and 9, each data byte yields `wr_en` high for exactly one cycle. The strobe comes on the cycle after the byte's second character is accepted, with `wr_off` equal to (record address − load base + byte index) and `wr_data` equal to the byte. Types 0, 4, 5, 6 and A-F produce no writes.
- R8: For record types below 7, `image_size` becomes (record address − load base) plus the number of data bytes in that record. Types 7 and above leave it unchanged.
- R9: A record of type 7 or higher with a correct checksum sets `done`, puts its address on `start_addr`, and halts. Records of lower type are followed by decoding of the next record.
- R10: While halted (after `done`, `err_nos` or `err_sum`), `in_ready` is 0, no character is taken, and no write is issued. A `restart` pulse returns every output to its reset value.
- R11: After reset, `in_ready` is 1, and `wr_en`, `done`, `err_nos`, `err_sum`, `base_valid` and `image_size` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Synchronous pulse returning the decoder to its reset state |
| in_valid | input | 1 | A character is offered |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | Decoder takes the offered character |
| wr_en | output | 1 | Write strobe for one data byte |
| wr_off | output | OFF_W | Byte offset from the load base |
| wr_data | output | 8 | Data byte |
| image_size | output | OFF_W | Running image size |
| base_valid | output | 1 | Load base has been latched |
| load_base | output | ADDR_W | Load base address |
| done | output | 1 | Termination record decoded |
| start_addr | output | ADDR_W | Address from the termination record |
| err_nos | output | 1 | A character other than 'S' or blank arrived where a record should start |
| err_sum | output | 1 | Checksum mismatch |
| err_addr | output | ADDR_W | Address of the record that failed its checksum |

## Verification
The hardest cases to reach are the record shapes that real tools seldom emit. These include a byte count too short to cover the address field, so that no data bytes remain. They also include records whose type has no address field but that still move the image size, and termination records that carry stored data. Directed streams build each of these with checksums computed in the bench, so a wrong field width shows up as a false checksum error or as misplaced writes. Random streams then mix address widths, letter case, blank characters and a corrupted final checksum, to show that writes issued before a failing checksum still match and that nothing follows the halt.

// File: rtl/srec_pkg.sv
package srec_pkg;

   typedef enum logic [3:0] {
      ST_SKIP,
      ST_TYPE,
      ST_LENH,
      ST_LENL,
      ST_ADDR,
      ST_DATH,
      ST_DATL,
      ST_CKH,
      ST_CKL,
      ST_HALT
   } srec_state_e;

   localparam logic [7:0] CH_CR = 8'h0D;
   localparam logic [7:0] CH_LF = 8'h0A;
   localparam logic [7:0] CH_SP = 8'h20;
   localparam logic [7:0] CH_S  = 8'h53;

endpackage

// File: rtl/srec_nibble.sv
module srec_nibble (
   input  logic [7:0] ch,
   output logic [3:0] nib
);
   logic [7:0] adj;

   always_comb begin
      adj = ch[6] ? (ch + 8'd9) : ch;
      nib = adj[3:0];
   end
endmodule

// File: rtl/srec_layout.sv
module srec_layout (
   input  logic [3:0] rtype,
   output logic [3:0] addr_chars,
   output logic       stores,
   output logic       sizes,
   output logic       ends
);
   always_comb begin
      unique case (rtype)
         4'd1, 4'd9: addr_chars = 4'd4;
         4'd2, 4'd8: addr_chars = 4'd6;
         4'd3, 4'd7: addr_chars = 4'd8;
         default:    addr_chars = 4'd0;
      endcase
      stores = (rtype == 4'd1) || (rtype == 4'd2) || (rtype == 4'd3) ||
               (rtype == 4'd7) || (rtype == 4'd8) || (rtype == 4'd9);
      sizes  = (rtype < 4'd7);
      ends   = !sizes;
   end
endmodule

// File: rtl/srec_sum.sv
module srec_sum (
   input  logic       clk,
   input  logic       clr,
   input  logic       load_en,
   input  logic [7:0] load_val,
   input  logic       add_en,
   input  logic [7:0] add_val,
   output logic [7:0] sum
);
   always_ff @(posedge clk) begin
      if (clr)          sum <= 8'd0;
      else if (load_en) sum <= load_val;
      else if (add_en)  sum <= sum + add_val;
   end
endmodule

// File: rtl/srec_stream_decoder.sv
module srec_stream_decoder #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              in_valid,
   input  logic [7:0]        in_char,
   output logic              in_ready,
   output logic              wr_en,
   output logic [OFF_W-1:0]  wr_off,
   output logic [7:0]        wr_data,
   output logic [OFF_W-1:0]  image_size,
   output logic              base_valid,
   output logic [ADDR_W-1:0] load_base,
   output logic              done,
   output logic [ADDR_W-1:0] start_addr,
   output logic              err_nos,
   output logic              err_sum,
   output logic [ADDR_W-1:0] err_addr
);
   import srec_pkg::*;

   localparam int MAX_ACH = 8;
   localparam int ACNT_W  = $clog2(MAX_ACH + 1);

   generate
      if (ADDR_W < 4 * MAX_ACH) begin : g_bad_addr_w
         $error("ADDR_W must hold the widest address field");
      end
      if (OFF_W > ADDR_W || OFF_W < 8) begin : g_bad_off_w
         $error("OFF_W must lie between 8 and ADDR_W");
      end
   endgenerate

   srec_state_e       state_q;
   logic [3:0]        rtype_q;
   logic [3:0]        hi_q;
   logic [ACNT_W-1:0] acnt_q;
   logic [7:0]        dbytes_q;
   logic [ADDR_W-1:0] rec_addr_q;
   logic [OFF_W-1:0]  cur_off_q;

   logic [3:0]        nib;
   logic [3:0]        addr_chars;
   logic              rec_stores, rec_sizes, rec_ends;
   logic [7:0]        sum;
   logic              clr;
   logic              take;
   logic [7:0]        pair_byte;
   logic [8:0]        dtmp;
   logic [7:0]        dbytes_calc;
   logic [ADDR_W-1:0] addr_shift;
   logic              hdr_fin;
   logic [ADDR_W-1:0] a_fin;
   logic              first_base;
   logic [ADDR_W-1:0] eff_base;
   logic [ADDR_W-1:0] off_full;
   logic [OFF_W-1:0]  off0;
   logic              sum_load, sum_add;
   logic [7:0]        sum_val;
   logic              is_blank;

   srec_nibble u_nib (
      .ch  (in_char),
      .nib (nib)
   );

   srec_layout u_lay (
      .rtype      (rtype_q),
      .addr_chars (addr_chars),
      .stores     (rec_stores),
      .sizes      (rec_sizes),
      .ends       (rec_ends)
   );

   always_comb begin
      clr         = !rst_n || restart;
      in_ready    = (state_q != ST_HALT);
      take        = in_valid && in_ready;
      pair_byte   = {hi_q, nib};
      dtmp        = {1'b0, pair_byte} - 9'd1 - {6'd0, addr_chars[3:1]};
      dbytes_calc = dtmp[8] ? 8'd0 : dtmp[7:0];
      addr_shift  = {rec_addr_q[ADDR_W-5:0], nib};
      hdr_fin     = take && (((state_q == ST_LENL) && (addr_chars == 4'd0)) ||
                             ((state_q == ST_ADDR) && (acnt_q == ACNT_W'(1))));
      a_fin       = (state_q == ST_ADDR) ? addr_shift : '0;
      first_base  = !base_valid && (rtype_q != 4'd0);
      eff_base    = first_base ? a_fin : load_base;
      off_full    = a_fin - eff_base;
      off0        = off_full[OFF_W-1:0];
      is_blank    = (in_char == CH_CR) || (in_char == CH_LF) || (in_char == CH_SP);
      sum_load    = take && (state_q == ST_LENL);
      sum_add     = take && (((state_q == ST_ADDR) && acnt_q[0]) || (state_q == ST_DATL));
      sum_val     = (state_q == ST_ADDR) ? {rec_addr_q[3:0], nib} : pair_byte;
   end

   srec_sum u_sum (
      .clk      (clk),
      .clr      (clr),
      .load_en  (sum_load),
      .load_val (pair_byte),
      .add_en   (sum_add),
      .add_val  (sum_val),
      .sum      (sum)
   );

   always_ff @(posedge clk) begin
      if (clr) begin
         state_q    <= ST_SKIP;
         rtype_q    <= 4'd0;
         hi_q       <= 4'd0;
         acnt_q     <= '0;
         dbytes_q   <= 8'd0;
         rec_addr_q <= '0;
         cur_off_q  <= '0;
         wr_en      <= 1'b0;
         wr_off     <= '0;
         wr_data    <= 8'd0;
         image_size <= '0;
         base_valid <= 1'b0;
         load_base  <= '0;
         done       <= 1'b0;
         start_addr <= '0;
         err_nos    <= 1'b0;
         err_sum    <= 1'b0;
         err_addr   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (hdr_fin) begin
            if (first_base) begin
               load_base  <= a_fin;
               base_valid <= 1'b1;
            end
            cur_off_q <= off0;
            if (rec_sizes) image_size <= off0;
         end
         if (take) begin
            unique case (state_q)
               ST_SKIP: begin
                  if (in_char == CH_S) begin
                     state_q <= ST_TYPE;
                  end else if (!is_blank) begin
                     err_nos <= 1'b1;
                     state_q <= ST_HALT;
                  end
               end
               ST_TYPE: begin
                  rtype_q <= nib;
                  state_q <= ST_LENH;
               end
               ST_LENH: begin
                  hi_q    <= nib;
                  state_q <= ST_LENL;
               end
               ST_LENL: begin
                  dbytes_q   <= dbytes_calc;
                  acnt_q     <= ACNT_W'(addr_chars);
                  rec_addr_q <= '0;
                  if (addr_chars != 4'd0)      state_q <= ST_ADDR;
                  else if (dbytes_calc != 8'd0) state_q <= ST_DATH;
                  else                          state_q <= ST_CKH;
               end
               ST_ADDR: begin
                  rec_addr_q <= addr_shift;
                  acnt_q     <= acnt_q - ACNT_W'(1);
                  if (acnt_q == ACNT_W'(1)) begin
                     state_q <= (dbytes_q != 8'd0) ? ST_DATH : ST_CKH;
                  end
               end
               ST_DATH: begin
                  hi_q    <= nib;
                  state_q <= ST_DATL;
               end
               ST_DATL: begin
                  if (rec_stores) begin
                     wr_en   <= 1'b1;
                     wr_off  <= cur_off_q;
                     wr_data <= pair_byte;
                  end
                  cur_off_q <= cur_off_q + OFF_W'(1);
                  if (rec_sizes) image_size <= cur_off_q + OFF_W'(1);
                  dbytes_q <= dbytes_q - 8'd1;
                  state_q  <= (dbytes_q == 8'd1) ? ST_CKH : ST_DATH;
               end
               ST_CKH: begin
                  hi_q    <= nib;
                  state_q <= ST_CKL;
               end
               ST_CKL: begin
                  if (~sum != pair_byte) begin
                     err_sum  <= 1'b1;
                     err_addr <= rec_addr_q;
                     state_q  <= ST_HALT;
                  end else if (rec_ends) begin
                     done       <= 1'b1;
                     start_addr <= rec_addr_q;
                     state_q    <= ST_HALT;
                  end else begin
                     state_q <= ST_SKIP;
                  end
               end
               default: state_q <= ST_HALT;
            endcase
         end
      end
   end

endmodule

// File: rtl/srec_stream_decoder_chk.sv
module srec_stream_decoder_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              restart,
   input logic              in_valid,
   input logic              in_ready,
   input logic              wr_en,
   input logic              base_valid,
   input logic [ADDR_W-1:0] load_base,
   input logic              done,
   input logic              err_nos,
   input logic              err_sum
);
   // R7
   wr_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(in_valid && in_ready));

   // R9
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && (err_sum || err_nos)));

   // R10
   halt_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err_sum || err_nos) |-> !in_ready);

   // R6
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (base_valid && !restart) |=> (base_valid && $stable(load_base)));

   // R10
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (in_ready && !done && !err_nos && !err_sum && !base_valid && !wr_en));

   // R9
   done_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(in_valid && in_ready));
endmodule

bind srec_stream_decoder srec_stream_decoder_chk #(
   .ADDR_W (ADDR_W),
   .OFF_W  (OFF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .restart    (restart),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .wr_en      (wr_en),
   .base_valid (base_valid),
   .load_base  (load_base),
   .done       (done),
   .err_nos    (err_nos),
   .err_sum    (err_sum)
);

// File: tb/srec_stream_decoder_test.sv
`timescale 1ns/1ps
module srec_stream_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        restart = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_char = 8'h00;
   logic        in_ready, wr_en, base_valid, done, err_nos, err_sum;
   logic [31:0] wr_off, image_size, load_base, start_addr, err_addr;
   logic [7:0]  wr_data;

   always #10 clk = ~clk;

   srec_stream_decoder #(.ADDR_W(32), .OFF_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
      .in_char(in_char), .in_ready(in_ready), .wr_en(wr_en), .wr_off(wr_off),
      .wr_data(wr_data), .image_size(image_size), .base_valid(base_valid),
      .load_base(load_base), .done(done), .start_addr(start_addr),
      .err_nos(err_nos), .err_sum(err_sum), .err_addr(err_addr));

   int n_chk = 0;
   int n_bad = 0;
   int wr_cnt = 0;
   int cyc = 0;

   logic [31:0] q_off[$];
   logic [7:0]  q_dat[$];
   logic [31:0] e_base, e_size, e_start, e_eaddr;
   bit          e_bv, e_done, e_esum, e_enos;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL R10 watchdog expired: actual %0d expected %0d", cyc, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   // write monitor (R7)
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         wr_cnt++;
         if (q_off.size() == 0) begin
            chk(1'b0, "R7", "unexpected write offset", wr_off, 32'hxxxxxxxx);
         end else begin
            logic [31:0] eo;
            logic [7:0]  ed;
            eo = q_off.pop_front();
            ed = q_dat.pop_front();
            chk(wr_off == eo, "R7", "write offset", wr_off, eo);
            chk(wr_data == ed, "R7", "write data", {24'd0, wr_data}, {24'd0, ed});
         end
      end
   end

   function automatic logic [7:0] hx(input int v, input bit lc);
      if (v < 10) return 8'(8'h30 + v);
      return lc ? 8'(8'h61 + v - 10) : 8'(8'h41 + v - 10);
   endfunction

   function automatic int achars_of(input int t);
      case (t)
         1, 9:    return 4;
         2, 8:    return 6;
         3, 7:    return 8;
         default: return 0;
      endcase
   endfunction

   task automatic send_char(input logic [7:0] c);
      int g;
      g = $urandom_range(0, 2);
      in_valid = 1'b0;
      repeat (g) @(negedge clk);
      in_valid = 1'b1;
      in_char  = c;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // builds a record with a bench-computed checksum and updates the model
   task automatic send_rec(input int t, input logic [31:0] a, input int n,
                           input bit bad, input bit lc, input int len_ovr);
      int ach, ab, len, nd;
      logic [31:0] ae, rel;
      logic [7:0] s, ck;
      logic [7:0] d[256];
      int nws;
      ach = achars_of(t);
      ab  = ach / 2;
      len = (len_ovr >= 0) ? len_ovr : ab + n + 1;
      nd  = len - 1 - ab;
      if (nd < 0) nd = 0;
      ae  = (ach == 0) ? 32'd0 : ((ach == 8) ? a : (a & ((32'd1 << (ach * 4)) - 1)));
      s   = 8'(len);
      for (int i = 0; i < ab; i++) s = s + ae[8*i +: 8];
      for (int i = 0; i < nd; i++) begin
         d[i] = 8'($urandom);
         s = s + d[i];
      end
      ck = ~s;
      if (bad) ck = ck ^ 8'h5A;
      if (t != 0 && !e_bv) begin
         e_bv = 1'b1;
         e_base = ae;
      end
      rel = ae - (e_bv ? e_base : 32'd0);
      if (t == 1 || t == 2 || t == 3 || t == 7 || t == 8 || t == 9)
         for (int i = 0; i < nd; i++) begin
            q_off.push_back(rel + 32'(i));
            q_dat.push_back(d[i]);
         end
      if (t < 7) e_size = rel + 32'(nd);
      if (bad) begin
         e_esum = 1'b1;
         e_eaddr = ae;
      end else if (t >= 7) begin
         e_done = 1'b1;
         e_start = ae;
      end
      nws = $urandom_range(0, 3);
      for (int i = 0; i < nws; i++) begin
         case ($urandom_range(0, 2))
            0: send_char(8'h0D);
            1: send_char(8'h0A);
            default: send_char(8'h20);
         endcase
      end
      send_char(8'h53);
      send_char(hx(t, lc));
      send_char(hx(len / 16, lc));
      send_char(hx(len % 16, lc));
      for (int i = ach - 1; i >= 0; i--) send_char(hx(int'(ae[4*i +: 4]), lc));
      for (int i = 0; i < nd; i++) begin
         send_char(hx(int'(d[i][7:4]), lc));
         send_char(hx(int'(d[i][3:0]), lc));
      end
      send_char(hx(int'(ck[7:4]), lc));
      send_char(hx(int'(ck[3:0]), lc));
   endtask

   task automatic model_clear();
      q_off.delete();
      q_dat.delete();
      e_base = 0; e_size = 0; e_start = 0; e_eaddr = 0;
      e_bv = 0; e_done = 0; e_esum = 0; e_enos = 0;
   endtask

   task automatic do_restart();
      @(negedge clk);
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      chk(in_ready == 1'b1, "R10", "ready after restart", {31'd0, in_ready}, 32'd1);
      chk(!done && !err_sum && !err_nos, "R10", "flags after restart",
          {29'd0, done, err_sum, err_nos}, 32'd0);
      chk(!base_valid && image_size == 0, "R10", "base/size after restart",
          image_size | {31'd0, base_valid}, 32'd0);
      model_clear();
   endtask

   task automatic end_stream(input string tag);
      repeat (3) @(negedge clk);
      chk(done == e_done, "R9", {tag, " done"}, {31'd0, done}, {31'd0, e_done});
      if (e_done) chk(start_addr == e_start, "R9", {tag, " start address"}, start_addr, e_start);
      chk(err_sum == e_esum, "R5", {tag, " checksum error flag"}, {31'd0, err_sum}, {31'd0, e_esum});
      if (e_esum) chk(err_addr == e_eaddr, "R5", {tag, " error address"}, err_addr, e_eaddr);
      chk(err_nos == e_enos, "R1", {tag, " missing-S flag"}, {31'd0, err_nos}, {31'd0, e_enos});
      chk(image_size == e_size, "R8", {tag, " image size"}, image_size, e_size);
      chk(base_valid == e_bv, "R6", {tag, " base valid"}, {31'd0, base_valid}, {31'd0, e_bv});
      if (e_bv) chk(load_base == e_base, "R6", {tag, " load base"}, load_base, e_base);
      chk(q_off.size() == 0, "R7", {tag, " missing writes"}, 32'(q_off.size()), 32'd0);
      if (e_done || e_esum || e_enos)
         chk(in_ready == 1'b0, "R10", {tag, " halted"}, {31'd0, in_ready}, 32'd0);
   endtask

   task automatic ignore_window();
      int w0;
      logic [31:0] sz, bs;
      w0 = wr_cnt; sz = image_size; bs = load_base;
      for (int i = 0; i < 12; i++) begin
         in_valid = 1'b1;
         in_char  = (i % 3 == 0) ? 8'h53 : hx($urandom_range(0, 15), 1'b0);
         @(negedge clk);
         chk(in_ready == 1'b0, "R10", "ready while halted", {31'd0, in_ready}, 32'd0);
      end
      in_valid = 1'b0;
      chk(wr_cnt == w0, "R10", "writes while halted", 32'(wr_cnt), 32'(w0));
      chk(image_size == sz && load_base == bs, "R10", "state moved while halted",
          image_size ^ load_base, sz ^ bs);
   endtask

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(in_ready == 1'b1, "R11", "ready after reset", {31'd0, in_ready}, 32'd1);
      chk(!wr_en && !done && !err_nos && !err_sum && !base_valid, "R11", "flags after reset",
          {27'd0, wr_en, done, err_nos, err_sum, base_valid}, 32'd0);
      chk(image_size == 0, "R11", "size after reset", image_size, 32'd0);

      // R2 R4 R6 R7: header in lower case, two data records, type 9 end
      send_rec(0, 32'h0, 3, 0, 1, -1);
      send_rec(1, 32'h1000, 4, 0, 0, -1);
      send_rec(1, 32'h1004, 3, 0, 1, -1);
      send_rec(9, 32'h1000, 0, 0, 0, -1);
      end_stream("directed type9");
      ignore_window();
      do_restart();

      // R3 every layout; R4 short count clamps data to zero; type 8 end
      send_rec(2, 32'h012340, 2, 0, 0, -1);
      send_rec(3, 32'h00012350, 3, 0, 1, -1);
      send_rec(5, 32'h0, 2, 0, 0, -1);
      send_rec(4, 32'h0, 1, 0, 1, -1);
      send_rec(6, 32'h0, 1, 0, 0, -1);
      send_rec(1, 32'h2345, 0, 0, 0, 1);
      send_rec(2, 32'h012360, 2, 0, 1, -1);
      send_rec(8, 32'hABCDEF, 0, 0, 0, -1);
      end_stream("all layouts R3");
      do_restart();

      // R7 R8: type 7 end record with data is stored but does not size
      send_rec(3, 32'h80000000, 5, 0, 0, -1);
      send_rec(7, 32'h80000004, 2, 0, 1, -1);
      end_stream("type7 data R8");
      do_restart();

      // R6 R9: only a header then a type A end; base comes from the end record
      send_rec(0, 32'h0, 4, 0, 1, -1);
      send_rec(10, 32'h0, 0, 0, 1, -1);
      end_stream("typeA end");
      do_restart();

      // R5: bad checksum halts after its writes
      send_rec(1, 32'h3000, 2, 0, 0, -1);
      send_rec(1, 32'h4000, 3, 1, 0, -1);
      end_stream("bad checksum R5");
      ignore_window();
      do_restart();

      // R1: blanks skipped, stray character raises the missing-S error
      send_rec(2, 32'h100000, 2, 0, 0, -1);
      send_char(8'h0D); send_char(8'h0A); send_char(8'h20);
      send_char(8'h51);
      e_enos = 1'b1;
      end_stream("missing S R1");
      ignore_window();
      do_restart();

      // random streams
      for (int s = 0; s < 40; s++) begin
         int t, nr, tt;
         logic [31:0] base;
         bit stop;
         t = $urandom_range(1, 3);
         base = $urandom;
         base[7:0] = 8'h00;
         stop = 1'b0;
         nr = $urandom_range(2, 7);
         for (int r = 0; r < nr && !stop; r++) begin
            bit bd;
            bd = ($urandom_range(0, 9) == 0);
            send_rec(t, base + 32'($urandom_range(0, 255)), $urandom_range(0, 8), bd,
                     $urandom_range(0, 1) == 1, -1);
            if (bd) stop = 1'b1;
         end
         if (!stop) begin
            tt = (t == 1) ? 9 : ((t == 2) ? 8 : 7);
            send_rec(tt, base, 0, 0, $urandom_range(0, 1) == 1, -1);
         end
         end_stream("random");
         do_restart();
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      process::self().srandom(32'h5EC0DE);
   end
endmodule